// File: doc/BRIEF.md
# Survivor Traceback and Bit-Order Restore Unit

This unit sits behind the add-compare-select array of a convolutional decoder. It keeps one decision bit per trellis state for each step of a packet. Once the last step of the packet has been stored, a state machine walks the stored decisions from the final step back to the first. It starts from the all-zero state, because the encoder was flushed with zero tail bits, and it rebuilds the decoded bit of each step. That walk produces bits newest first, so they are pushed onto a bit stack and popped in transmitted order through a valid/ready stream. The stream flags the final bit.

A two-bit mode word is latched when a packet is accepted. Its upper bit picks the long code (K=7, 64 states) or the short code (K=5, 16 states). The code rate is carried in its lower bit and has no effect here. The packet length in steps, tail included, comes with the start pulse. A length above the storage limit is clipped to that limit and flagged. The block takes no new packet until the last decoded bit has left.

The control state machine has four states. IDLE waits for a start pulse and goes to FILL on a non-zero length; a zero length keeps it in IDLE. FILL stores survivor words and goes to TRACE on the write that completes the packet. TRACE performs one traceback step per cycle. On the step for step 0 it goes to DRAIN if any bits were kept, and otherwise back to IDLE. DRAIN streams out the stack and returns to IDLE when the final bit is transferred.

Top module: `surv_traceback`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0 and len_err is 0.
- R2: A start pulse is taken only while in_ready is 1, and cfg_mode is latched with it. cfg_mode[1]=0 selects K=5: 16 states, with only wr_surv[15:0] used and a 4-bit state. cfg_mode[1]=1 selects K=7: 64 states and a 6-bit state. cfg_mode[0] has no effect on the output. A start with a length of 0 leaves the block idle.
- R3: In FILL, each cycle with wr_valid high stores wr_surv as the next step, counting from step 0. wr_valid is ignored in every other state.
- R4: Traceback starts only on the cycle after the write of the last step. It takes exactly N cycles for N steps. out_valid first goes high N cycles after the clock edge that captured the last write.
- R5: Traceback starts in state 0 at step N-1. At step t the decoded bit is the state MSB (bit 3 for K=5, bit 5 for K=7). The state for step t-1 is ((state << 1) | wr_surv_t[state]) masked to K-1 bits.
- R6: The last K-1 decoded steps are tail and are dropped. N-(K-1) bits are output, or none when N <= K-1.
- R7: Bits leave in transmitted order: the bit of step 0 first.
- R8: While out_valid is high and out_ready is low, out_bit and out_last hold. out_last is high only with the final bit. After that bit is transferred, out_valid drops and in_ready rises.
- R9: in_ready stays low from the accepted start until the final bit is transferred. A start pulse in that time is ignored.
- R10: A length above 612 is clipped to 612, and len_err goes high on the cycle after the start. len_err holds until the next accepted start, which clears it when its length is 612 or less.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Mode word: bit 1 selects the code length, bit 0 is the rate and is unused |
| pkt_len | input | 10 | Packet length in steps, tail included |
| pkt_start | input | 1 | Start pulse for a packet |
| in_ready | output | 1 | High while idle and able to take a start |
| wr_valid | input | 1 | A survivor word is present |
| wr_surv | input | 64 | Decision bits, where bit s belongs to state s |
| out_valid | output | 1 | A decoded bit is offered |
| out_ready | input | 1 | The consumer accepts the bit |
| out_bit | output | 1 | Decoded bit |
| out_last | output | 1 | Marks the final decoded bit |
| len_err | output | 1 | The requested length was clipped |

## Verification
len_err is due one cycle after an accepted start, and the bench samples it at the falling edge that follows. After the edge that stores the final write, out_valid must stay low for exactly N falling-edge samples and be high on the next one. For packets with no kept bits, in_ready must be back at that same sample instead. Each decoded bit is compared at the falling edge where out_ready is driven high, so the value checked is the one transferred at the next rising edge. Near-exhaustive sweeps over every mode and every short length run beside full-size and clipped packets, with random stalls, writes and start pulses placed where they must be ignored.

// File: rtl/svtb_pkg.sv
package svtb_pkg;
    typedef enum logic [1:0] {
        PH_IDLE,
        PH_FILL,
        PH_TRACE,
        PH_DRAIN
    } tb_phase_e;
endpackage

// File: rtl/svtb_surv_mem.sv
module svtb_surv_mem #(
    parameter int DEPTH = 612,
    parameter int WIDTH = 64,
    parameter int AW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/svtb_lifo.sv
module svtb_lifo #(
    parameter int DEPTH = 612,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          push_bit,
    input  logic          pop,
    output logic          top_bit,
    output logic [CW-1:0] count
);
    logic          bits [DEPTH];
    logic [CW-1:0] ptr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (push) begin
            ptr <= ptr + CW'(1);
        end else if (pop && ptr != '0) begin
            ptr <= ptr - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            bits[ptr] <= push_bit;
        end
    end

    assign top_bit = (ptr == '0) ? 1'b0 : bits[ptr - CW'(1)];
    assign count   = ptr;
endmodule

// File: rtl/svtb_trace_ctrl.sv
module svtb_trace_ctrl
    import svtb_pkg::*;
#(
    parameter int MAX_STEPS = 612,
    parameter int SURV_W    = 64,
    parameter int LEN_W     = 10,
    parameter int STEP_W    = $clog2(MAX_STEPS + 1),
    parameter int ST_W      = $clog2(SURV_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_big,
    input  logic [LEN_W-1:0]  pkt_len,
    input  logic              pkt_start,
    input  logic              wr_valid,
    input  logic [SURV_W-1:0] rd_word,
    input  logic [STEP_W-1:0] lifo_cnt,
    input  logic              out_ready,
    output logic              in_ready,
    output logic              mem_we,
    output logic [STEP_W-1:0] mem_waddr,
    output logic [STEP_W-1:0] mem_raddr,
    output logic              lifo_push,
    output logic              lifo_push_bit,
    output logic              lifo_pop,
    output logic              out_valid,
    output logic              out_last,
    output logic              len_err
);
    tb_phase_e         phase, phase_nx;
    logic              big_q;
    logic [STEP_W-1:0] n_steps, wr_cnt, tb_t;
    logic [ST_W-1:0]   tb_state;
    logic              len_err_q;

    logic              over;
    logic [STEP_W-1:0] len_clip;
    logic [STEP_W-1:0] tail_n;
    logic [STEP_W-1:0] keep_n;
    logic [ST_W-1:0]   st_mask;
    logic              dec_bit;
    logic              surv_bit;
    logic [ST_W-1:0]   pred;
    logic              last_wr;

    assign over     = pkt_len > LEN_W'(MAX_STEPS);
    assign len_clip = over ? STEP_W'(MAX_STEPS) : STEP_W'(pkt_len);
    assign tail_n   = big_q ? STEP_W'(ST_W) : STEP_W'(ST_W - 2);
    assign keep_n   = (n_steps > tail_n) ? (n_steps - tail_n) : '0;
    assign st_mask  = big_q ? {ST_W{1'b1}} : {2'b00, {(ST_W-2){1'b1}}};
    assign dec_bit  = big_q ? tb_state[ST_W-1] : tb_state[ST_W-3];
    assign surv_bit = rd_word[tb_state];
    assign pred     = {tb_state[ST_W-2:0], surv_bit} & st_mask;
    assign last_wr  = wr_valid && (wr_cnt == n_steps - STEP_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
        end else begin
            phase <= phase_nx;
        end
    end

    always_comb begin
        phase_nx = phase;
        unique case (phase)
            PH_IDLE:  if (pkt_start) phase_nx = (len_clip == '0) ? PH_IDLE : PH_FILL;
            PH_FILL:  if (last_wr) phase_nx = PH_TRACE;
            PH_TRACE: if (tb_t == '0) phase_nx = (keep_n != '0) ? PH_DRAIN : PH_IDLE;
            PH_DRAIN: if (out_ready && lifo_cnt == STEP_W'(1)) phase_nx = PH_IDLE;
            default:  phase_nx = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            big_q     <= 1'b0;
            n_steps   <= '0;
            wr_cnt    <= '0;
            tb_t      <= '0;
            tb_state  <= '0;
            len_err_q <= 1'b0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (pkt_start) begin
                        big_q     <= cfg_big;
                        n_steps   <= len_clip;
                        len_err_q <= over;
                        wr_cnt    <= '0;
                    end
                end
                PH_FILL: begin
                    if (wr_valid) begin
                        wr_cnt <= wr_cnt + STEP_W'(1);
                    end
                    if (last_wr) begin
                        tb_t     <= wr_cnt;
                        tb_state <= '0;
                    end
                end
                PH_TRACE: begin
                    if (tb_t != '0) begin
                        tb_t <= tb_t - STEP_W'(1);
                    end
                    tb_state <= pred;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        in_ready      = (phase == PH_IDLE);
        mem_we        = (phase == PH_FILL) && wr_valid;
        mem_waddr     = wr_cnt;
        mem_raddr     = tb_t;
        lifo_push     = (phase == PH_TRACE) && (tb_t < keep_n);
        lifo_push_bit = dec_bit;
        lifo_pop      = (phase == PH_DRAIN) && out_ready;
        out_valid     = (phase == PH_DRAIN);
        out_last      = (phase == PH_DRAIN) && (lifo_cnt == STEP_W'(1));
        len_err       = len_err_q;
    end
endmodule

// File: rtl/surv_traceback.sv
module surv_traceback #(
    parameter int MAX_STEPS = 612,
    parameter int SURV_W    = 64,
    parameter int LEN_W     = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_mode,
    input  logic [LEN_W-1:0]  pkt_len,
    input  logic              pkt_start,
    output logic              in_ready,
    input  logic              wr_valid,
    input  logic [SURV_W-1:0] wr_surv,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_bit,
    output logic              out_last,
    output logic              len_err
);
    localparam int STEP_W = $clog2(MAX_STEPS + 1);

    logic              rate_unused;
    logic              mem_we;
    logic [STEP_W-1:0] mem_waddr, mem_raddr;
    logic [SURV_W-1:0] rd_word;
    logic              lifo_push, lifo_push_bit, lifo_pop;
    logic [STEP_W-1:0] lifo_cnt;

    assign rate_unused = cfg_mode[0];

    svtb_surv_mem #(
        .DEPTH (MAX_STEPS),
        .WIDTH (SURV_W),
        .AW    (STEP_W)
    ) mem_i (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (wr_surv),
        .raddr (mem_raddr),
        .rdata (rd_word)
    );

    svtb_trace_ctrl #(
        .MAX_STEPS (MAX_STEPS),
        .SURV_W    (SURV_W),
        .LEN_W     (LEN_W),
        .STEP_W    (STEP_W)
    ) ctrl_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_big       (cfg_mode[1]),
        .pkt_len       (pkt_len),
        .pkt_start     (pkt_start),
        .wr_valid      (wr_valid),
        .rd_word       (rd_word),
        .lifo_cnt      (lifo_cnt),
        .out_ready     (out_ready),
        .in_ready      (in_ready),
        .mem_we        (mem_we),
        .mem_waddr     (mem_waddr),
        .mem_raddr     (mem_raddr),
        .lifo_push     (lifo_push),
        .lifo_push_bit (lifo_push_bit),
        .lifo_pop      (lifo_pop),
        .out_valid     (out_valid),
        .out_last      (out_last),
        .len_err       (len_err)
    );

    svtb_lifo #(
        .DEPTH (MAX_STEPS),
        .CW    (STEP_W)
    ) lifo_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (lifo_push),
        .push_bit (lifo_push_bit),
        .pop      (lifo_pop),
        .top_bit  (out_bit),
        .count    (lifo_cnt)
    );
endmodule

// File: rtl/surv_traceback_chk.sv
module surv_traceback_chk #(
    parameter int MAX_STEPS = 612,
    parameter int LEN_W     = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LEN_W-1:0] pkt_len,
    input logic             pkt_start,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic             out_bit,
    input logic             out_last,
    input logic             len_err
);
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready); // R9

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_bit) && $stable(out_last))); // R8

    AST_LAST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> (in_ready && !out_valid)); // R8

    AST_CLIP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && pkt_start && pkt_len > LEN_W'(MAX_STEPS)) |=> len_err); // R10

    AST_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && pkt_start && pkt_len <= LEN_W'(MAX_STEPS)) |=> !len_err); // R10

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && pkt_start) |=> $stable(len_err)); // R10
endmodule

bind surv_traceback surv_traceback_chk #(
    .MAX_STEPS (MAX_STEPS),
    .LEN_W     (LEN_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pkt_len   (pkt_len),
    .pkt_start (pkt_start),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_bit   (out_bit),
    .out_last  (out_last),
    .len_err   (len_err)
);

// File: tb/surv_traceback_tb_top.sv
module surv_traceback_tb_top;
    localparam int MAXS  = 612;
    localparam int LEN_W = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       cfg_mode = '0;
    logic [LEN_W-1:0] pkt_len = '0;
    logic             pkt_start = 1'b0;
    logic             in_ready;
    logic             wr_valid = 1'b0;
    logic [63:0]      wr_surv = '0;
    logic             out_valid;
    logic             out_ready = 1'b0;
    logic             out_bit;
    logic             out_last;
    logic             len_err;

    int          n_chk = 0;
    int          n_fail = 0;
    logic [31:0] seed = 32'h1234_5678;
    logic [63:0] words [MAXS];
    logic        exp_bits [MAXS];

    always #2 clk = ~clk;

    surv_traceback dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_mode  (cfg_mode),
        .pkt_len   (pkt_len),
        .pkt_start (pkt_start),
        .in_ready  (in_ready),
        .wr_valid  (wr_valid),
        .wr_surv   (wr_surv),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_bit   (out_bit),
        .out_last  (out_last),
        .len_err   (len_err)
    );

    function automatic logic [31:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic run_packet(input logic [1:0] cfg, input int len, input bit stall,
                              input bit gaps, input bit spurious, input string tag);
        int n, sw, n_out, s_prev, s, t, idx, guard;
        bit ok;
        n     = (len > MAXS) ? MAXS : len;
        sw    = cfg[1] ? 6 : 4;
        n_out = (n > sw) ? n - sw : 0;
        s_prev = 0;
        for (int i = 0; i < n; i++) begin
            logic b;
            b = (i < n_out) ? rnd()[7] : 1'b0;
            exp_bits[i] = b;
            s = (int'(b) << (sw - 1)) | (s_prev >> 1);
            words[i] = {rnd(), rnd()};
            words[i][s] = s_prev[0];
            s_prev = s;
        end
        chk(in_ready == 1'b1, "R9", "idle before start", in_ready, 1);
        pkt_start = 1'b1;
        pkt_len   = LEN_W'(len);
        cfg_mode  = cfg;
        @(negedge clk);
        pkt_start = 1'b0;
        chk(len_err == (len > MAXS), "R10", "len_err after start", len_err, (len > MAXS));
        if (n == 0) begin
            chk(in_ready == 1'b1, "R2", "zero length stays idle", in_ready, 1);
            return;
        end
        chk(in_ready == 1'b0, "R9", "busy after start", in_ready, 0);
        t = 0;
        while (t < n) begin
            if (gaps && (rnd() % 3 == 0)) begin
                wr_valid = 1'b0;
                wr_surv  = {rnd(), rnd()};
            end else begin
                wr_valid = 1'b1;
                wr_surv  = words[t];
                t++;
            end
            @(negedge clk);
        end
        // R3: writes offered during traceback must be ignored
        ok = 1'b1;
        for (int k = 0; k < n; k++) begin
            wr_valid = 1'b1;
            wr_surv  = {rnd(), rnd()};
            if (out_valid) ok = 1'b0;
            if (spurious && k == 0) begin
                pkt_start = 1'b1;
                pkt_len   = LEN_W'(5);
            end
            @(negedge clk);
            pkt_start = 1'b0;
        end
        wr_valid = 1'b0;
        if (n_out > 0)
            chk(ok && out_valid, "R4", "traceback cycle count", out_valid, 1);
        else
            chk(ok && in_ready && !out_valid, "R6", "no kept bits returns idle", in_ready, 1);
        idx = 0;
        guard = 0;
        while (idx < n_out && guard < 8 * MAXS) begin
            guard++;
            out_ready = stall ? rnd()[3] : 1'b1;
            if (spurious) begin
                pkt_start = rnd()[9];
                pkt_len   = LEN_W'(3);
            end
            if (!out_valid) begin
                chk(1'b0, "R8", "valid dropped early", out_valid, 1);
                idx = n_out;
            end else if (out_ready) begin
                chk(out_bit == exp_bits[idx], tag, "decoded bit", out_bit, exp_bits[idx]);
                chk(out_last == (idx == n_out - 1), "R8", "last flag", out_last, (idx == n_out - 1));
                idx++;
            end
            @(negedge clk);
        end
        out_ready = 1'b0;
        pkt_start = 1'b0;
        chk(in_ready && !out_valid, "R6", "idle after kept bits", in_ready, 1);
        chk(len_err == (len > MAXS), "R10", "len_err held", len_err, (len > MAXS));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R4 watchdog expired: actual 0 expected 1");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(in_ready == 1'b1, "R1", "in_ready at reset", in_ready, 1);
        chk(out_valid == 1'b0, "R1", "out_valid at reset", out_valid, 0);
        chk(len_err == 1'b0, "R1", "len_err at reset", len_err, 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_packet(2'b00, 20, 1'b0, 1'b0, 1'b0, "R5");
        run_packet(2'b10, 40, 1'b1, 1'b1, 1'b1, "R7");
        run_packet(2'b01, 5, 1'b0, 1'b0, 1'b0, "R6");
        run_packet(2'b11, 6, 1'b0, 1'b0, 1'b0, "R6");
        run_packet(2'b10, 7, 1'b1, 1'b0, 1'b0, "R6");
        run_packet(2'b00, 700, 1'b1, 1'b0, 1'b1, "R10");
        run_packet(2'b11, 612, 1'b0, 1'b1, 1'b0, "R3");
        for (int c = 0; c < 4; c++) begin
            for (int l = 0; l < 14; l++) begin
                run_packet(c[1:0], l, l[0], l[1], l[2], "R2");
            end
        end
        run_packet(2'b01, 30, 1'b1, 1'b1, 1'b1, "R5");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule